// File: doc/BRIEF.md
# Branch Target Instruction Cache

The block stores, for recently taken branches, the first two instructions of each branch's target stream. These are kept in a small set-associative array that is indexed by the branch's own address. The fetch unit presents a branch address on the lookup port. If the entry is present, the two target instructions come out registered on the next clock, so the instruction queue can be filled in the cycle after the branch is seen, before the instruction cache has been accessed for the target.

The cache holds 64 entries arranged as 16 sets of 4 ways. When a taken branch has been resolved and its target instructions fetched, the fetch unit writes them through the allocate port. Replacement within a set fills empty ways first and otherwise follows a three-bit tree pseudo-LRU. A global enable turns the whole structure off. A single-cycle invalidate input drops every entry at once. The block does not compute target addresses and does not hold the instruction cache.

Top module: `btic`

## Requirements
- R1: The set index is branch address bits [5:2] and the tag is bits [31:6]; address bits [1:0] take no part in lookup or allocation.
- R2: A lookup (lk_valid high) that matches a valid entry gives lk_hit=1 and that entry's two instructions on lk_insn0/lk_insn1 one clock later. A miss, or a cycle with no lookup, gives lk_hit=0 and both instruction outputs zero.
- R3: An allocation stores its tag and both instructions, and lookups issued on any later cycle find them.
- R4: Allocating an address already present rewrites that way with the new instructions; no second copy is created and the other ways of the set are kept.
- R5: When allocating a new tag into a set that has empty ways, the lowest-numbered empty way is used.
- R6: In a full set the victim is chosen from the set's pseudo-LRU bits {b2,b1,b0}: b0=0 selects way b1 (way 0 or 1), and b0=1 selects way 2+b2.
- R7: A lookup hit or an allocation to way w updates that set's bits to point away from w: for w<2, b0=1 and b1=~w[0]; for w>=2, b0=0 and b2=~w[0]. When both happen in one set on the same clock, the allocation's update is kept.
- R8: While enable is low, lookups always miss and allocations are dropped; entries stored earlier survive and are found again once enable returns high.
- R9: invalidate_all clears every valid bit in one clock, and a lookup issued in that same cycle misses.
- R10: When invalidate_all and an allocation arrive together, the invalidation wins and nothing is stored.
- R11: After reset every entry is invalid and all pseudo-LRU bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global cache enable |
| invalidate_all | input | 1 | Drop all entries this cycle |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Branch address to look up |
| lk_hit | output | 1 | Registered hit flag |
| lk_insn0 | output | 32 | First target instruction on a hit |
| lk_insn1 | output | 32 | Second target instruction on a hit |
| al_valid | input | 1 | Allocate request |
| al_addr | input | 32 | Branch address to allocate |
| al_insn0 | input | 32 | First target instruction to store |
| al_insn1 | input | 32 | Second target instruction to store |

## Verification
Lookup results pass through one register, so hit and instructions are due exactly one clock after the request. An allocation or invalidation takes effect at that same edge and is seen by any lookup issued on a later cycle. The bench drives each request at a falling edge and samples the outputs one nanosecond after the next rising edge. It then removes the request, so every comparison falls in the single cycle it is due. A bench-side model applies the fill, victim and pseudo-LRU rules to all 16 sets, so each eviction in the sweeps is predicted before it happens.

// File: rtl/btic.sv
module btic #(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32,
  parameter int SETS   = 16,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              invalidate_all,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [INSN_W-1:0] lk_insn0,
  output logic [INSN_W-1:0] lk_insn1,
  input  logic              al_valid,
  input  logic [ADDR_W-1:0] al_addr,
  input  logic [INSN_W-1:0] al_insn0,
  input  logic [INSN_W-1:0] al_insn1
);
  localparam int WAYS  = 4;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [SETS-1:0][WAYS-1:0] vld_q;
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [INSN_W-1:0] i0_q  [SETS][WAYS];
  logic [INSN_W-1:0] i1_q  [SETS][WAYS];
  logic [2:0]        plru_q [SETS];

  function automatic logic [1:0] first_set(input logic [3:0] v);
    if (v[0]) return 2'd0;
    if (v[1]) return 2'd1;
    if (v[2]) return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [1:0] victim(input logic [2:0] p);
    return p[0] ? {1'b1, p[2]} : {1'b0, p[1]};
  endfunction

  function automatic logic [2:0] touch(input logic [2:0] p, input logic [1:0] w);
    return w[1] ? {~w[0], p[1], 1'b0} : {p[2], ~w[0], 1'b1};
  endfunction

  wire [IDX_W-1:0] lk_idx = lk_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] al_idx = al_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] al_tag = al_addr[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0] lk_match, al_match;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_match[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
    assign al_match[w] = vld_q[al_idx][w] && (tag_q[al_idx][w] == al_tag);
  end

  wire             lk_go  = lk_valid && enable && !invalidate_all && |lk_match;
  wire [1:0]       lk_way = first_set(lk_match);
  wire             al_go  = al_valid && enable && !invalidate_all;
  wire [WAYS-1:0]  al_free = ~vld_q[al_idx];
  wire [1:0]       al_way = |al_match ? first_set(al_match)
                          : |al_free  ? first_set(al_free)
                          : victim(plru_q[al_idx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int s = 0; s < SETS; s++) plru_q[s] <= '0;
      lk_hit   <= 1'b0;
      lk_insn0 <= '0;
      lk_insn1 <= '0;
    end else begin
      if (invalidate_all) vld_q <= '0;
      else if (al_go) vld_q[al_idx][al_way] <= 1'b1;
      if (lk_go) plru_q[lk_idx] <= touch(plru_q[lk_idx], lk_way);
      if (al_go) plru_q[al_idx] <= touch(plru_q[al_idx], al_way);
      lk_hit   <= lk_go;
      lk_insn0 <= lk_go ? i0_q[lk_idx][lk_way] : '0;
      lk_insn1 <= lk_go ? i1_q[lk_idx][lk_way] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (al_go) begin
      tag_q[al_idx][al_way] <= al_tag;
      i0_q[al_idx][al_way]  <= al_insn0;
      i1_q[al_idx][al_way]  <= al_insn1;
    end
  end
endmodule

// File: rtl/btic_chk.sv
module btic_chk #(
  parameter int SETS  = 16,
  parameter int TAG_W = 26
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   enable,
  input logic                   invalidate_all,
  input logic                   lk_valid,
  input logic                   lk_hit,
  input logic [SETS*4-1:0]      vld,
  input logic [TAG_W-1:0]       tags [SETS][4]
);
  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int s = 0; s < SETS; s++)
      for (int i = 0; i < 4; i++)
        for (int j = i + 1; j < 4; j++)
          if (vld[s*4+i] && vld[s*4+j] && tags[s][i] == tags[s][j]) dup = 1'b1;
  end

  AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $past(lk_valid)) else $error("hit without request"); // R2
  AST_DISABLED_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable) |-> !lk_hit) else $error("hit while disabled"); // R8
  AST_INVAL_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(invalidate_all) |-> !lk_hit) else $error("hit during invalidate"); // R9
  AST_INVAL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(invalidate_all) |-> (vld == '0)) else $error("entry survived invalidate"); // R10
  AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    !dup) else $error("duplicate tag in set"); // R4
endmodule

bind btic btic_chk #(.SETS(SETS), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .invalidate_all(invalidate_all),
  .lk_valid(lk_valid), .lk_hit(lk_hit), .vld(vld_q), .tags(tag_q)
);

// File: tb/tb_btic.sv
`timescale 1ns/1ps
module tb_btic;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b1, invalidate_all = 1'b0;
  logic lk_valid = 1'b0, al_valid = 1'b0;
  logic [31:0] lk_addr = '0, al_addr = '0, al_insn0 = '0, al_insn1 = '0;
  logic lk_hit;
  logic [31:0] lk_insn0, lk_insn1;
  int n_chk = 0, n_bad = 0, seq = 0;

  always #5 clk = ~clk;

  btic dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .invalidate_all(invalidate_all),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_insn0(lk_insn0), .lk_insn1(lk_insn1),
    .al_valid(al_valid), .al_addr(al_addr), .al_insn0(al_insn0), .al_insn1(al_insn1)
  );

  logic        mv [16][4];
  logic [25:0] mt [16][4];
  logic [31:0] m0 [16][4];
  logic [31:0] m1 [16][4];
  logic [2:0]  mp [16];

  function automatic logic [31:0] mk(input int tag, input int idx);
    return {tag[25:0], idx[3:0], 2'b00};
  endfunction

  function automatic logic [2:0] touch(input logic [2:0] p, input int w);
    return (w >= 2) ? {~w[0], p[1], 1'b0} : {p[2], ~w[0], 1'b1};
  endfunction

  task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 16; s++) begin
      mp[s] = 3'b000;
      for (int w = 0; w < 4; w++) mv[s][w] = 1'b0;
    end
  endtask

  task automatic alloc(input logic [31:0] a, input bit inv);
    int s, way;
    s = a[5:2];
    way = -1;
    @(negedge clk);
    seq++;
    al_valid = 1'b1; al_addr = a; invalidate_all = inv;
    al_insn0 = {seq[15:0], a[15:0]};
    al_insn1 = a ^ {seq[15:0], 16'hBEEF};
    if (inv) begin
      for (int x = 0; x < 16; x++) for (int w = 0; w < 4; w++) mv[x][w] = 1'b0;
    end else if (enable) begin
      for (int w = 3; w >= 0; w--) if (mv[s][w] && mt[s][w] == a[31:6]) way = w;
      if (way < 0) for (int w = 3; w >= 0; w--) if (!mv[s][w]) way = w;
      if (way < 0) way = mp[s][0] ? (2 + mp[s][2]) : mp[s][1];
      mv[s][way] = 1'b1; mt[s][way] = a[31:6];
      m0[s][way] = al_insn0; m1[s][way] = al_insn1;
      mp[s] = touch(mp[s], way);
    end
    @(posedge clk); #1;
    al_valid = 1'b0; invalidate_all = 1'b0;
  endtask

  task automatic lookup(input string req, input logic [31:0] a, input bit inv);
    int s, way;
    logic [64:0] exp;
    s = a[5:2];
    way = -1;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; invalidate_all = inv;
    for (int w = 3; w >= 0; w--) if (mv[s][w] && mt[s][w] == a[31:6]) way = w;
    if (way < 0 || !enable || inv) exp = '0;
    else begin
      exp = {1'b1, m0[s][way], m1[s][way]};
      mp[s] = touch(mp[s], way);
    end
    if (inv) for (int x = 0; x < 16; x++) for (int w = 0; w < 4; w++) mv[x][w] = 1'b0;
    @(posedge clk); #1;
    chk(req, {lk_hit, lk_insn0, lk_insn1}, exp);
    lk_valid = 1'b0; invalidate_all = 1'b0;
  endtask

  initial begin
    #(200_000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 chk("R11 reset outputs", {lk_hit, lk_insn0, lk_insn1}, '0);
    for (int s = 0; s < 16; s++) lookup("R11 empty after reset", mk(1, s), 0);

    // R1 R3 R5: fill every set, then read everything back
    for (int s = 0; s < 16; s++) for (int t = 1; t <= 4; t++) alloc(mk(t * 7 + s, s), 0);
    for (int s = 0; s < 16; s++) for (int t = 1; t <= 4; t++) lookup("R3 stored entry", mk(t * 7 + s, s), 0);
    for (int s = 0; s < 16; s++) lookup("R2 absent tag misses", mk(1000 + s, s), 0);
    for (int s = 0; s < 16; s++) lookup("R1 low bits ignored", mk(7 + s, s) | 32'h3, 0);
    lookup("R1 other set index misses", mk(7 + 2, 3), 0);

    // R6 R7: eviction walk in set 5, with lookups steering the pseudo-LRU
    for (int k = 0; k < 12; k++) begin
      if (k % 3 == 1) lookup("R7 hit steers replacement", mk(200 + k - 1, 5), 0);
      alloc(mk(200 + k, 5), 0);
      for (int t = 0; t <= k; t++) lookup("R6 victim choice", mk(200 + t, 5), 0);
      lookup("R6 original tag", mk(7 + 5, 5), 0);
    end

    // R4: overwrite an existing address
    alloc(mk(14 + 9, 9), 0);
    for (int t = 1; t <= 4; t++) lookup("R4 overwrite keeps set", mk(t * 7 + 9, 9), 0);
    alloc(mk(500, 9), 0);
    for (int t = 1; t <= 4; t++) lookup("R4 no duplicate way", mk(t * 7 + 9, 9), 0);
    lookup("R4 new tag", mk(500, 9), 0);

    // R8: disabled
    @(negedge clk) enable = 1'b0;
    lookup("R8 disabled lookup misses", mk(7 + 2, 2), 0);
    alloc(mk(777, 4), 0);
    @(negedge clk) enable = 1'b1;
    lookup("R8 disabled alloc dropped", mk(777, 4), 0);
    for (int t = 1; t <= 4; t++) lookup("R8 entries survive disable", mk(t * 7 + 4, 4), 0);

    // R9: invalidate with concurrent lookup
    lookup("R9 lookup during invalidate", mk(7 + 2, 2), 1);
    for (int s = 0; s < 16; s++) for (int t = 1; t <= 4; t++) lookup("R9 all invalid", mk(t * 7 + s, s), 0);

    // R10: invalidate beats allocate
    alloc(mk(321, 6), 1);
    lookup("R10 alloc lost to invalidate", mk(321, 6), 0);
    alloc(mk(322, 6), 0);
    lookup("R5 refill after invalidate", mk(322, 6), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule